// File: doc/BRIEF.md
# SPI Receive Holding Register with Overrun Detection

This block sits between an SPI shift register and a processor's register bus. Each time the shifter finishes a byte, it pulses a completion strobe with the byte beside it. The block keeps the most recent accepted byte in a readable data register. A status register holds two flags: a receive-full flag and an overrun flag. It also holds two interrupt enables that software can write. The block drives one interrupt request from these flags.

Software clears each flag with an ordered pair of bus reads. First it reads the status register while the flag is set, which arms that flag. Then it reads the data register, which clears every armed flag.

The flags interact. A byte that arrives while the buffer is full is dropped and sets the overrun flag. While the overrun flag is set, every later byte is dropped and the receive-full flag stays clear. If the overrun flag sets after software has already read the status register, the following data read leaves it set. A second status read then shows it. Serial clocking, the shifter itself, mode-fault detection and the transmit side belong to other blocks.

Top module: `spi_rx_buffer`

## Requirements
- R1: A completion strobe while both flags are clear loads the byte into the data register and sets the receive-full flag (status bit 7).
- R2: A status read taken while receive-full is set, followed by a data read, clears receive-full. A data read with no such armed status read leaves receive-full set.
- R3: A data read clears the overrun flag (status bit 6) only when the preceding status read saw overrun set. If overrun sets after the status read, the data read leaves it set, and the next status read shows it.
- R4: A completion strobe while receive-full is set sets the overrun flag and drops the byte. The data register keeps the older byte.
- R5: While the overrun flag is set, completion strobes are dropped. They do not set receive-full and they do not change the data register.
- R6: A pending clear armed by a status read survives any completion strobes that arrive before the data read.
- R7: Address 0 is the status register and address 1 is the data register. A status read returns receive-full in bit 7, overrun in bit 6, the error interrupt enable in bit 1, the receive interrupt enable in bit 0, and zeros elsewhere. A status write updates only bits 1:0. A data write has no effect. Read data appears on the bus the cycle after the read strobe.
- R8: The interrupt request equals (receive-full AND receive enable) OR (overrun AND error enable). It changes on the same clock edge as the flags and enables.
- R9: Synchronous reset clears both flags, both enables, the arm state and the interrupt request, and sets the data register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | 1 | One-cycle strobe from the shifter: a byte has completed |
| rx_byte | input | DATA_W | Byte from the shifter, valid with rx_done |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = status register, 1 = data register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
A wrong arm bit shows up two bus reads later. A flag stays set after a data read that should have cleared it, or clears when no armed status read came first. Either way the next status read exposes it. A wrong overrun decision shows the next cycle, because the interrupt request follows the flags on the same edge. It also shows at the next data read as the wrong byte. A receive-full flag left clear while overrun is set hides every later byte, so the tests drive extra strobes in that state and confirm that nothing changes.

// File: rtl/spi_rxb_pkg.sv
package spi_rxb_pkg;
  typedef enum logic {
    REG_STAT = 1'b0,
    REG_DATA = 1'b1
  } reg_sel_e;

  localparam int FLAG_FULL = 0;
  localparam int FLAG_OVR  = 1;
  localparam int NUM_FLAGS = 2;

  localparam int EN_RX  = 0;
  localparam int EN_ERR = 1;
endpackage

// File: rtl/spi_rxb_bus_dec.sv
module spi_rxb_bus_dec
  import spi_rxb_pkg::*;
(
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic bus_addr,
  output logic stat_rd,
  output logic data_rd,
  output logic stat_wr,
  output logic data_wr
);
  reg_sel_e sel;

  always_comb begin
    sel     = reg_sel_e'(bus_addr);
    stat_rd = bus_rd && (sel == REG_STAT);
    data_rd = bus_rd && (sel == REG_DATA);
    stat_wr = bus_wr && (sel == REG_STAT);
    data_wr = bus_wr && (sel == REG_DATA);
  end
endmodule

// File: rtl/spi_rxb_flag_cell.sv
module spi_rxb_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic stat_rd_i,
  input  logic data_rd_i,
  output logic flag_q,
  output logic flag_d,
  output logic arm_q
);
  logic arm_d;
  logic clr;

  always_comb begin
    clr    = data_rd_i && arm_q;
    flag_d = set_i || (flag_q && !clr);
    if (stat_rd_i)      arm_d = flag_q;
    else if (data_rd_i) arm_d = 1'b0;
    else                arm_d = arm_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/spi_rxb_flags.sv
module spi_rxb_flags
  import spi_rxb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_done,
  input  logic                 stat_rd,
  input  logic                 data_rd,
  output logic [NUM_FLAGS-1:0] flag_q,
  output logic [NUM_FLAGS-1:0] flag_d,
  output logic [NUM_FLAGS-1:0] arm_q,
  output logic                 load_en
);
  logic [NUM_FLAGS-1:0] set_vec;

  always_comb begin
    load_en            = rx_done && !flag_q[FLAG_FULL] && !flag_q[FLAG_OVR];
    set_vec[FLAG_FULL] = load_en;
    set_vec[FLAG_OVR]  = rx_done && flag_q[FLAG_FULL];
  end

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
    spi_rxb_flag_cell u_cell (
      .clk       (clk),
      .rst       (rst),
      .set_i     (set_vec[g]),
      .stat_rd_i (stat_rd),
      .data_rd_i (data_rd),
      .flag_q    (flag_q[g]),
      .flag_d    (flag_d[g]),
      .arm_q     (arm_q[g])
    );
  end
endmodule

// File: rtl/spi_rxb_datareg.sv
module spi_rxb_datareg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] data_q
);
  always_ff @(posedge clk) begin
    if (rst)          data_q <= '0;
    else if (load_en) data_q <= din;
  end
endmodule

// File: rtl/spi_rxb_ctrl.sv
module spi_rxb_ctrl
  import spi_rxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 stat_rd,
  input  logic                 data_rd,
  input  logic                 stat_wr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_FLAGS-1:0] flag_q,
  input  logic [NUM_FLAGS-1:0] flag_d,
  input  logic [DATA_W-1:0]    data_q,
  output logic [1:0]           en_q,
  output logic [DATA_W-1:0]    rdata_q,
  output logic                 irq_q
);
  localparam int BIT_FULL = DATA_W - 1;
  localparam int BIT_OVR  = DATA_W - 2;

  logic [1:0]        en_d;
  logic [DATA_W-1:0] stat_word;

  always_comb begin
    en_d = stat_wr ? wdata[1:0] : en_q;
    stat_word            = '0;
    stat_word[BIT_FULL]  = flag_q[FLAG_FULL];
    stat_word[BIT_OVR]   = flag_q[FLAG_OVR];
    stat_word[1:0]       = en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      en_q  <= en_d;
      irq_q <= (flag_d[FLAG_FULL] && en_d[EN_RX]) ||
               (flag_d[FLAG_OVR]  && en_d[EN_ERR]);
      if (stat_rd)      rdata_q <= stat_word;
      else if (data_rd) rdata_q <= data_q;
    end
  end
endmodule

// File: rtl/spi_rx_buffer.sv
module spi_rx_buffer
  import spi_rxb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic                 stat_rd, data_rd, stat_wr, data_wr;
  logic [NUM_FLAGS-1:0] flag_q, flag_d, arm_q;
  logic                 load_en;
  logic [DATA_W-1:0]    data_q;
  logic [1:0]           en_q;

  spi_rxb_bus_dec u_dec (
    .bus_rd  (bus_rd),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .stat_rd (stat_rd),
    .data_rd (data_rd),
    .stat_wr (stat_wr),
    .data_wr (data_wr)
  );

  spi_rxb_flags u_flags (
    .clk    (clk),
    .rst    (rst),
    .rx_done(rx_done),
    .stat_rd(stat_rd),
    .data_rd(data_rd),
    .flag_q (flag_q),
    .flag_d (flag_d),
    .arm_q  (arm_q),
    .load_en(load_en)
  );

  spi_rxb_datareg #(.DATA_W(DATA_W)) u_data (
    .clk    (clk),
    .rst    (rst),
    .load_en(load_en),
    .din    (rx_byte),
    .data_q (data_q)
  );

  spi_rxb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .stat_rd(stat_rd),
    .data_rd(data_rd),
    .stat_wr(stat_wr),
    .wdata  (bus_wdata),
    .flag_q (flag_q),
    .flag_d (flag_d),
    .data_q (data_q),
    .en_q   (en_q),
    .rdata_q(bus_rdata),
    .irq_q  (irq)
  );

  logic unused_data_wr;
  assign unused_data_wr = data_wr;
endmodule

// File: rtl/spi_rx_buffer_chk.sv
module spi_rx_buffer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_done,
  input logic [DATA_W-1:0] rx_byte,
  input logic              data_rd,
  input logic [1:0]        flag_q,
  input logic [1:0]        arm_q,
  input logic [DATA_W-1:0] data_q,
  input logic [1:0]        en_q,
  input logic              irq
);
  AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (rst)
    rx_done && flag_q == 2'b00 |=> flag_q[0] && data_q == $past(rx_byte)); // R1

  AST_FULL_CLR_ARMED: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q[0]) |-> $past(data_rd && arm_q[0]) || $past(rst)); // R2

  AST_OVR_CLR_ARMED: assert property (@(posedge clk) disable iff (rst)
    $fell(flag_q[1]) |-> $past(data_rd && arm_q[1]) || $past(rst)); // R3

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (rst)
    rx_done && flag_q[0] |=> flag_q[1] && $stable(data_q)); // R4

  AST_DROP_IN_OVR: assert property (@(posedge clk) disable iff (rst)
    rx_done && flag_q[1] && !flag_q[0] |=> !flag_q[0] && $stable(data_q)); // R5

  AST_IRQ_MAP: assert property (@(posedge clk) disable iff (rst)
    irq == ((flag_q[0] && en_q[0]) || (flag_q[1] && en_q[1]))); // R8

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> flag_q == 2'b00 && arm_q == 2'b00 && !irq && data_q == '0); // R9
endmodule

bind spi_rx_buffer spi_rx_buffer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rx_done(rx_done),
  .rx_byte(rx_byte),
  .data_rd(data_rd),
  .flag_q (flag_q),
  .arm_q  (arm_q),
  .data_q (data_q),
  .en_q   (en_q),
  .irq    (irq)
);

// File: tb/tb_spi_rx_buffer.sv
module tb_spi_rx_buffer;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_done = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic          bus_addr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_rx_buffer #(.DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .rx_done(rx_done), .rx_byte(rx_byte),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // op: 0 byte strobe, 1 status read, 2 data read, 3 status write
  localparam int NV = 26;
  localparam logic [21:0] VEC [NV] = '{
    {4'd7, 2'd3, 8'h03, 8'h00},  // R7 enable both
    {4'd7, 2'd1, 8'h00, 8'h03},  // R7 status layout
    {4'd1, 2'd0, 8'h11, 8'h00},  // R1 load
    {4'd1, 2'd1, 8'h00, 8'h83},  // R1 full set, arms
    {4'd2, 2'd2, 8'h00, 8'h11},  // R2 data read
    {4'd2, 2'd1, 8'h00, 8'h03},  // R2 full cleared
    {4'd1, 2'd0, 8'h22, 8'h00},  // R1 byte 2
    {4'd6, 2'd1, 8'h00, 8'h83},  // R6 arm full
    {4'd4, 2'd0, 8'h33, 8'h00},  // R4 byte 3 overruns
    {4'd4, 2'd2, 8'h00, 8'h22},  // R4 older byte kept
    {4'd3, 2'd1, 8'h00, 8'h43},  // R3 ovr survived data read
    {4'd5, 2'd0, 8'h44, 8'h00},  // R5 dropped
    {4'd5, 2'd1, 8'h00, 8'h43},  // R5 full still clear
    {4'd3, 2'd2, 8'h00, 8'h22},  // R3 clears ovr
    {4'd3, 2'd1, 8'h00, 8'h03},  // R3 both clear
    {4'd1, 2'd0, 8'h55, 8'h00},  // R1 load after recovery
    {4'd2, 2'd2, 8'h00, 8'h55},  // R2 unarmed data read
    {4'd2, 2'd1, 8'h00, 8'h83},  // R2 full kept
    {4'd2, 2'd2, 8'h00, 8'h55},  // R2 armed clear
    {4'd2, 2'd1, 8'h00, 8'h03},  // R2 cleared
    {4'd1, 2'd0, 8'h66, 8'h00},  // R1
    {4'd6, 2'd1, 8'h00, 8'h83},  // R6 arm full
    {4'd6, 2'd0, 8'h77, 8'h00},  // R6 overrun between reads
    {4'd6, 2'd0, 8'h78, 8'h00},  // R6 another strobe
    {4'd6, 2'd2, 8'h00, 8'h66},  // R6 still clears full
    {4'd6, 2'd1, 8'h00, 8'h43}   // R6 only ovr remains
  };

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_byte(input logic [DW-1:0] b);
    @(negedge clk); rx_done = 1'b1; rx_byte = b;
    @(negedge clk); rx_done = 1'b0;
  endtask

  task automatic do_read(input logic a, output logic [DW-1:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic do_write(input logic a, input logic [DW-1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R9 reset state
    check("R9 irq", {7'b0, irq}, 8'h00);
    do_read(1'b0, v); check("R9 status", v, 8'h00);
    do_read(1'b1, v); check("R9 data", v, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      logic [1:0] op;
      rq = VEC[i][21:18]; op = VEC[i][17:16];
      case (op)
        2'd0: do_byte(VEC[i][15:8]);
        2'd3: do_write(1'b0, VEC[i][15:8]);
        default: begin
          do_read(op == 2'd2, v);
          check($sformatf("R%0d vec%0d", rq, i), v, VEC[i][7:0]);
        end
      endcase
    end

    // R7 data write ignored, status write touches only enables
    do_reset();
    do_byte(8'h9C);
    do_write(1'b1, 8'hAA);
    do_write(1'b0, 8'hFC);
    do_read(1'b0, v); check("R7 status write masked", v, 8'h80);
    do_read(1'b1, v); check("R7 data write ignored", v, 8'h9C);

    // R8 interrupt mapping
    do_reset();
    do_write(1'b0, 8'h01);
    check("R8 idle irq", {7'b0, irq}, 8'h00);
    do_byte(8'h5A);
    check("R8 rx irq", {7'b0, irq}, 8'h01);
    do_write(1'b0, 8'h00);
    check("R8 rx irq masked", {7'b0, irq}, 8'h00);
    do_write(1'b0, 8'h02);
    check("R8 full without rx enable", {7'b0, irq}, 8'h00);
    do_byte(8'h6B);
    check("R8 ovr irq", {7'b0, irq}, 8'h01);
    do_write(1'b0, 8'h00);
    check("R8 ovr irq masked", {7'b0, irq}, 8'h00);

    // R9 reset with flags set
    do_write(1'b0, 8'h03);
    do_reset();
    check("R9 irq after reset", {7'b0, irq}, 8'h00);
    do_read(1'b0, v); check("R9 status after reset", v, 8'h00);
    do_read(1'b1, v); check("R9 data after reset", v, 8'h00);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule